// File: doc/BRIEF.md
# Three-Port Latched Data Exchanger

This block joins a processor address/data port (X) to two memory data ports: an even bank (Y) and an odd bank (Z). Each memory port has two latches of its own. One latch carries write data from X towards that memory. The other latch carries read data from that memory towards X. Each latch is level-sensitive. It follows its input while its enable is high and keeps the last value once the enable goes low. Two controls pick the route: a direction control and a bank select. Active-low per-byte-lane enables then decide which lanes of the routed port drive.

Each bidirectional port is split into three parts: an input vector, an output vector and a per-lane output-enable vector. The pad driver stays outside the block. The bank select acts only on routing, never on the latches. A memory controller can therefore capture one bank while the other bank's read latch is presented on X. This allows two-way interleaved reads. With every latch enable held high, the block acts as a plain transceiver.

Top module: `bus_exchanger`

## Requirements
- R1: While `wr_y_le` is 1, `y_out` follows `x_in`. From the cycle in which `wr_y_le` falls, `y_out` keeps the value `x_in` had then, whatever `x_in` does afterwards.
- R2: The Z write latch behaves the same way under `wr_z_le` and drives `z_out`. It is independent of the Y write latch: loading one latch never changes the other latch's output.
- R3: Each read latch follows its own memory input while its enable is 1 and holds from the fall of that enable. Under `rd_y_le` the Y read latch follows `y_in`. Under `rd_z_le` the Z read latch follows `z_in`.
- R4: `x_out` shows the Y read latch when `path_even` is 1 and the Z read latch when `path_even` is 0.
- R5: With `xmit` = 0 (read), lane i of `x_oe` is 1 exactly when `lane_oe_n[i]` is 0, and all of `y_oe` and `z_oe` are 0.
- R6: With `xmit` = 1 (write), `x_oe` is all 0. `y_oe` carries the enabled lanes when `path_even` is 1, and `z_oe` carries them when `path_even` is 0. The unselected memory port has all lanes off.
- R7: The lane enables are active low. Bit 1 covers data bits 15:8 and bit 0 covers bits 7:0. With both bits at 1, no output-enable bit is set on any port.
- R8: `path_even` never changes latch contents. A read latch can capture its bank while `path_even` selects the other bank. After `path_even` flips, `x_out` shows the newly captured data.
- R9: With all four latch enables at 1, `y_out` and `z_out` equal `x_in`, and `x_out` equals the selected memory input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 16 | Processor port data as seen on the bus |
| x_out | output | 16 | Data driven towards the processor port |
| x_oe | output | 2 | Per-lane drive enable for the processor port |
| y_in | input | 16 | Even bank data as seen on the bus |
| y_out | output | 16 | Write data towards the even bank |
| y_oe | output | 2 | Per-lane drive enable for the even bank port |
| z_in | input | 16 | Odd bank data as seen on the bus |
| z_out | output | 16 | Write data towards the odd bank |
| z_oe | output | 2 | Per-lane drive enable for the odd bank port |
| wr_y_le | input | 1 | Even write latch enable (open when 1) |
| wr_z_le | input | 1 | Odd write latch enable (open when 1) |
| rd_y_le | input | 1 | Even read latch enable (open when 1) |
| rd_z_le | input | 1 | Odd read latch enable (open when 1) |
| path_even | input | 1 | Bank select: 1 = even (Y), 0 = odd (Z) |
| xmit | input | 1 | Direction: 1 = write to memory, 0 = read to processor |
| lane_oe_n | input | 2 | Active-low lane enables, bit 1 upper byte, bit 0 lower byte |

## Verification
A capture into one bank's read latch can coincide with the other bank's latch being presented on X. The bench provokes this by opening `rd_z_le` and changing `z_in` while `path_even` is 1. It checks that `x_out` still shows the held even data. It then closes the odd latch, flips `path_even`, and checks that the freshly captured odd word appears. The same is repeated with the banks swapped. In the same way, loading one write latch while the other holds is judged by checking that the holding port's output does not change.

// File: rtl/bx_pkg.sv
package bx_pkg;

  typedef enum logic [1:0] {
    RT_READ     = 2'd0,
    RT_WR_EVEN  = 2'd1,
    RT_WR_ODD   = 2'd2
  } route_e;

  function automatic route_e pick_route(input logic xmit, input logic path_even);
    if (!xmit)
      return RT_READ;
    else if (path_even)
      return RT_WR_EVEN;
    else
      return RT_WR_ODD;
  endfunction

endpackage

// File: rtl/bx_latch.sv
module bx_latch #(
  parameter int W = 16
) (
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_latch begin
    if (le)
      q <= d;
  end

endmodule

// File: rtl/bx_lane_decode.sv
module bx_lane_decode #(
  parameter int LANES = 2
) (
  input  logic             xmit,
  input  logic             path_even,
  input  logic [LANES-1:0] lane_oe_n,
  output logic [LANES-1:0] x_oe,
  output logic [LANES-1:0] y_oe,
  output logic [LANES-1:0] z_oe
);
  import bx_pkg::*;

  route_e route;

  always_comb begin
    route = pick_route(xmit, path_even);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign x_oe[i] = (route == RT_READ)    && !lane_oe_n[i];
    assign y_oe[i] = (route == RT_WR_EVEN) && !lane_oe_n[i];
    assign z_oe[i] = (route == RT_WR_ODD)  && !lane_oe_n[i];
  end

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] x_in,
  output logic [DATA_W-1:0] x_out,
  output logic [LANES-1:0]  x_oe,
  input  logic [DATA_W-1:0] y_in,
  output logic [DATA_W-1:0] y_out,
  output logic [LANES-1:0]  y_oe,
  input  logic [DATA_W-1:0] z_in,
  output logic [DATA_W-1:0] z_out,
  output logic [LANES-1:0]  z_oe,
  input  logic              wr_y_le,
  input  logic              wr_z_le,
  input  logic              rd_y_le,
  input  logic              rd_z_le,
  input  logic              path_even,
  input  logic              xmit,
  input  logic [LANES-1:0]  lane_oe_n
);

  logic [DATA_W-1:0] rd_y_q;
  logic [DATA_W-1:0] rd_z_q;

  // write side: processor data towards each bank
  bx_latch #(.W(DATA_W)) u_wr_y (.le(wr_y_le), .d(x_in), .q(y_out));
  bx_latch #(.W(DATA_W)) u_wr_z (.le(wr_z_le), .d(x_in), .q(z_out));

  // read side: each bank towards the processor
  bx_latch #(.W(DATA_W)) u_rd_y (.le(rd_y_le), .d(y_in), .q(rd_y_q));
  bx_latch #(.W(DATA_W)) u_rd_z (.le(rd_z_le), .d(z_in), .q(rd_z_q));

  always_comb begin
    x_out = path_even ? rd_y_q : rd_z_q;
  end

  bx_lane_decode #(.LANES(LANES)) u_dec (
    .xmit      (xmit),
    .path_even (path_even),
    .lane_oe_n (lane_oe_n),
    .x_oe      (x_oe),
    .y_oe      (y_oe),
    .z_oe      (z_oe)
  );

endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic [DATA_W-1:0] x_in,
  input logic [DATA_W-1:0] x_out,
  input logic [LANES-1:0]  x_oe,
  input logic [DATA_W-1:0] y_in,
  input logic [DATA_W-1:0] y_out,
  input logic [LANES-1:0]  y_oe,
  input logic [DATA_W-1:0] z_out,
  input logic [LANES-1:0]  z_oe,
  input logic              wr_y_le,
  input logic              rd_y_le,
  input logic              path_even,
  input logic [LANES-1:0]  lane_oe_n
);

  always_comb begin
    // R5/R6: processor port never drives together with a memory port
    a_r5_x_mem_exclusive: assert (!((|x_oe) && ((|y_oe) || (|z_oe))));
    // R6: the two memory ports never drive together
    a_r6_yz_exclusive: assert (!((|y_oe) && (|z_oe)));
    // R7: all lanes disabled means nothing drives
    if (&lane_oe_n)
      a_r7_all_off: assert (!(|x_oe) && !(|y_oe) && !(|z_oe));
    // R1: open even write latch is transparent
    if (wr_y_le)
      a_r1_wr_open: assert (y_out == x_in);
    // R3/R4: open even read latch seen on X when even selected
    if (rd_y_le && path_even)
      a_r3_rd_open: assert (x_out == y_in);
  end

endmodule

bind bus_exchanger bus_exchanger_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .x_in      (x_in),
  .x_out     (x_out),
  .x_oe      (x_oe),
  .y_in      (y_in),
  .y_out     (y_out),
  .y_oe      (y_oe),
  .z_out     (z_out),
  .z_oe      (z_oe),
  .wr_y_le   (wr_y_le),
  .rd_y_le   (rd_y_le),
  .path_even (path_even),
  .lane_oe_n (lane_oe_n)
);

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] x_in, y_in, z_in;
  logic [15:0] x_out, y_out, z_out;
  logic [1:0]  x_oe, y_oe, z_oe;
  logic wr_y_le, wr_z_le, rd_y_le, rd_z_le, path_even, xmit;
  logic [1:0]  lane_oe_n;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  bus_exchanger uut (
    .x_in(x_in), .x_out(x_out), .x_oe(x_oe),
    .y_in(y_in), .y_out(y_out), .y_oe(y_oe),
    .z_in(z_in), .z_out(z_out), .z_oe(z_oe),
    .wr_y_le(wr_y_le), .wr_z_le(wr_z_le),
    .rd_y_le(rd_y_le), .rd_z_le(rd_z_le),
    .path_even(path_even), .xmit(xmit), .lane_oe_n(lane_oe_n)
  );

  // {xmit, path_even, lane_oe_n[1], lane_oe_n[0], x_oe, y_oe, z_oe}
  localparam logic [9:0] VEC [16] = '{
    10'b0000_11_00_00, 10'b0001_10_00_00, 10'b0010_01_00_00, 10'b0011_00_00_00,
    10'b0100_11_00_00, 10'b0101_10_00_00, 10'b0110_01_00_00, 10'b0111_00_00_00,
    10'b1000_00_00_11, 10'b1001_00_00_10, 10'b1010_00_00_01, 10'b1011_00_00_00,
    10'b1100_00_11_00, 10'b1101_00_10_00, 10'b1110_00_01_00, 10'b1111_00_00_00
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    x_in = 16'h0; y_in = 16'h0; z_in = 16'h0;
    wr_y_le = 1'b0; wr_z_le = 1'b0; rd_y_le = 1'b0; rd_z_le = 1'b0;
    path_even = 1'b1; xmit = 1'b0; lane_oe_n = 2'b11;
    settle();
    // R7: idle with both lane enables high
    chk("R7 idle x_oe", {14'd0, x_oe}, 16'd0);
    chk("R7 idle y_oe", {14'd0, y_oe}, 16'd0);
    chk("R7 idle z_oe", {14'd0, z_oe}, 16'd0);

    // truth table with all latches open (R5, R6, R7, R9)
    for (int i = 0; i < 16; i++) begin
      step();
      {xmit, path_even, lane_oe_n} = VEC[i][9:6];
      wr_y_le = 1'b1; wr_z_le = 1'b1; rd_y_le = 1'b1; rd_z_le = 1'b1;
      x_in = 16'hA5C3 ^ 16'(i * 16'h1111);
      y_in = 16'h3C00 + 16'(i);
      z_in = 16'hC300 + 16'(i);
      settle();
      chk(xmit ? "R6 x_oe" : "R5 x_oe", {14'd0, x_oe}, {14'd0, VEC[i][5:4]});
      chk(xmit ? "R6 y_oe" : "R5 y_oe", {14'd0, y_oe}, {14'd0, VEC[i][3:2]});
      chk(xmit ? "R6 z_oe" : "R5 z_oe", {14'd0, z_oe}, {14'd0, VEC[i][1:0]});
      chk("R9 y_out", y_out, x_in);
      chk("R9 z_out", z_out, x_in);
      chk("R9 x_out", x_out, path_even ? y_in : z_in);
    end

    // R1: even write latch holds after falling enable
    step(); wr_z_le = 1'b0; x_in = 16'h1234;
    step(); wr_y_le = 1'b0;
    step(); x_in = 16'hFFFF;
    settle();
    chk("R1 y hold", y_out, 16'h1234);

    // R2: load odd write latch, even stays
    step(); wr_z_le = 1'b1; x_in = 16'hABCD;
    step(); wr_z_le = 1'b0;
    step(); x_in = 16'h0F0F;
    settle();
    chk("R2 z hold", z_out, 16'hABCD);
    chk("R2 y untouched", y_out, 16'h1234);

    // R3/R4: read latches hold
    step(); rd_z_le = 1'b0; y_in = 16'h1111;
    step(); rd_y_le = 1'b0;
    step(); y_in = 16'h9999; path_even = 1'b1; xmit = 1'b0;
    settle();
    chk("R3 y read hold", x_out, 16'h1111);

    // R8: interleave, capture odd while even shown
    step(); rd_z_le = 1'b1; z_in = 16'h2222;
    settle();
    chk("R8 even shown during odd capture", x_out, 16'h1111);
    step(); rd_z_le = 1'b0;
    step(); z_in = 16'h7777; path_even = 1'b0;
    settle();
    chk("R4 odd selected", x_out, 16'h2222);
    // capture even while odd shown
    step(); rd_y_le = 1'b1; y_in = 16'h3333;
    settle();
    chk("R8 odd shown during even capture", x_out, 16'h2222);
    step(); rd_y_le = 1'b0;
    step(); y_in = 16'h8888; path_even = 1'b1;
    settle();
    chk("R8 even new word", x_out, 16'h3333);
    // R8: path toggles leave latch contents alone
    step(); path_even = 1'b0;
    step(); path_even = 1'b1;
    step(); path_even = 1'b0;
    settle();
    chk("R8 odd after toggles", x_out, 16'h2222);
    chk("R8 write y after toggles", y_out, 16'h1234);
    chk("R8 write z after toggles", z_out, 16'hABCD);

    // R7: single lane on write path
    step(); xmit = 1'b1; path_even = 1'b0; lane_oe_n = 2'b01;
    settle();
    chk("R7 upper lane odd", {14'd0, z_oe}, 16'd2);
    chk("R6 even off", {14'd0, y_oe}, 16'd0);

    finish_run();
  end

endmodule